// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside an 8-bit microcontroller core and decides which of six interrupt sources the core should service next. Each source delivers single-cycle event pulses. A pulse sets a latched request bit that stays set until software clears it or the source is granted. Every source has its own enable bit, and a global enable gates all of them together. A 3-bit priority code picks one of six rotating orderings of the sources. The highest-ranked pending source drives a vector-table address to the core. In a typical system the two timer end-of-count pulses are wired to sources 4 and 5.

The core reads and writes the request, enable and priority registers through a small register port. It also drives four strobes. The enable and disable strobes set or clear the global enable. The acknowledge strobe marks entry into the interrupt machine cycle: it clears the winner's request bit and blocks further interrupts. The return strobe restores the global enable to the value it had before the grant. After reset the request register is held at zero, and only the first enable strobe releases it. Writing the global-enable bit by register access does not release it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request register, the enable register (including the global enable in bit 7) and the priority register all read zero, and `irq_pending` is low.
- R2: Until the first `ei_stb` pulse after reset, the request register stays zero. This holds whatever arrives on `src_evt` or is written to address 0, and also when bit 7 of address 1 has been written to one.
- R3: Once released, a pulse on `src_evt[n]` sets request bit n, and the bit stays set. Address 0 reads the request bits in bits 5:0, and a write to address 0 replaces them.
- R4: `irq_pending` is high exactly when some source has its request bit, its enable bit and the global enable all set.
- R5: Priority code k in 0..5 ranks the sources k, k+1, …, 5, 0, …, k-1, and codes 6 and 7 rank like code 0. The winner is the first pending source in that ranking.
- R6: `vec_addr` equals twice the winning source index, so source n points at program address 2·n.
- R7: An `ack` pulse while `irq_pending` is high clears only the winner's request bit and clears the global enable.
- R8: If the winner's event input pulses in the same cycle as `ack`, that request bit stays set.
- R9: A `reti_stb` pulse restores the global enable to the value it held just before the most recent grant.
- R10: After release, writing bit 7 of address 1 to one has the same effect as `ei_stb`. Writing it to zero, or pulsing `di_stb`, clears the global enable.
- R11: Register map: address 1 holds the source enables in bits 5:0 and the global enable in bit 7, with bit 6 reading zero. Address 2 holds the priority code in bits 2:0. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 6 | Single-cycle event pulses, one per source |
| reg_addr | input | 2 | Register select: 0 request, 1 enable, 2 priority |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ei_stb | input | 1 | Enable-interrupts command |
| di_stb | input | 1 | Disable-interrupts command |
| ack | input | 1 | Core enters the interrupt machine cycle |
| reti_stb | input | 1 | Return from interrupt |
| irq_pending | output | 1 | An enabled request is waiting |
| vec_addr | output | 16 | Vector-table address of the winning source |

## Verification
The selection logic is swept with all 63 non-empty request patterns under every one of the eight priority codes, all enables on. This separates each rotation from its neighbours and shows that codes 6 and 7 alias to code 0. A second sweep holds every request set and walks all 64 enable patterns, which tells per-source gating apart from request latching. Directed sequences cover the locked request register before release, the grant clearing a single bit, an event colliding with the acknowledge, and the return restoring the global enable.

// File: rtl/irq_ctl_pkg.sv
// Shared constants and the register-address encoding for the interrupt
// controller. Assumes the data path is one byte wide.
package irq_ctl_pkg;

    typedef enum logic [1:0] {
        ADDR_REQ  = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_PRIO = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // Bit position of the global enable inside the enable register.
    localparam int GIE_BIT = 7;

endpackage

// File: rtl/irq_req_bank.sv
// Latched request bits. The bank stays forced to zero until the first
// enable command (arm_set) after reset. Events win over clears and
// register writes in the same cycle. Assumes clr is one-hot or zero.
module irq_req_bank #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_set,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] req_q
);

    logic armed_q;
    logic armed_nx;
    logic [NUM_SRC-1:0] base_v;

    assign armed_nx = armed_q | arm_set;
    assign base_v   = wr_en ? wr_data : req_q;

    // Release latch: set by the first enable command, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else if (arm_set) armed_q <= 1'b1;
    end

    // Request bits: held at zero while locked, else write/clear/event update.
    always_ff @(posedge clk) begin
        if (!rst_n)         req_q <= '0;
        else if (!armed_nx) req_q <= '0;
        else                req_q <= (base_v & ~clr) | evt;
    end

    AST_REQ_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (req_q == '0)); // R2

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr)); // R7

endmodule

// File: rtl/irq_prio_arb.sv
// Rotating-priority selector. The code picks the first source in the ranking;
// codes at or above NUM_SRC fall back to ranking 0. Purely combinational;
// clk/rst_n serve the assertions only.
module irq_prio_arb #(
    parameter int NUM_SRC = 6,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [PRIO_W-1:0]  prio_sel,
    output logic               any_pend,
    output logic [IDX_W-1:0]   win_idx
);

    // Scan the ranking starting at the selected base and take the first hit.
    always_comb begin
        int base;
        int s;
        logic found;
        base    = (int'(prio_sel) < NUM_SRC) ? int'(prio_sel) : 0;
        found   = 1'b0;
        win_idx = '0;
        for (int p = 0; p < NUM_SRC; p++) begin
            s = base + p;
            if (s >= NUM_SRC) s = s - NUM_SRC;
            if (!found && pend[s]) begin
                found   = 1'b1;
                win_idx = IDX_W'(s);
            end
        end
        any_pend = found;
    end

    AST_WINNER_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |-> pend[win_idx]); // R5

    AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !any_pend); // R4

endmodule

// File: rtl/irq_ctl_regs.sv
// Source enables, global enable with its pre-grant copy, and priority code.
// Command precedence on the global enable: grant, return, enable, disable,
// then a register write. Assumes grant is only raised with a pending source.
module irq_ctl_regs #(
    parameter int NUM_SRC = 6,
    parameter int PRIO_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               gie_wdata,
    input  logic               prio_wr,
    input  logic [PRIO_W-1:0]  prio_wdata,
    input  logic               ei_stb,
    input  logic               di_stb,
    input  logic               grant,
    input  logic               reti_stb,
    output logic [NUM_SRC-1:0] src_en,
    output logic               gie,
    output logic [PRIO_W-1:0]  prio_q
);

    logic saved_q;

    // Per-source enable bits, written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n)       src_en <= '0;
        else if (mask_wr) src_en <= mask_wdata;
    end

    // Priority code, written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n)       prio_q <= '0;
        else if (prio_wr) prio_q <= prio_wdata;
    end

    // Global enable and the copy taken at grant for the return strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie     <= 1'b0;
            saved_q <= 1'b0;
        end else if (grant) begin
            saved_q <= gie;
            gie     <= 1'b0;
        end else if (reti_stb) begin
            gie <= saved_q;
        end else if (ei_stb) begin
            gie <= 1'b1;
        end else if (di_stb) begin
            gie <= 1'b0;
        end else if (mask_wr) begin
            gie <= gie_wdata;
        end
    end

    AST_GRANT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !gie); // R7

    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_stb && !grant) |=> (gie == $past(saved_q))); // R9

endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the interrupt controller: register decode and read-back, pending
// gating, grant handling and vector address generation. Assumes the core
// drives at most one strobe per cycle and samples reg_rdata combinationally.
module irq_prio_ctrl #(
    parameter int NUM_SRC    = 6,
    parameter int DATA_W     = 8,
    parameter int PRIO_W     = 3,
    parameter int VEC_W      = 16,
    parameter int VEC_STRIDE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               ei_stb,
    input  logic               di_stb,
    input  logic               ack,
    input  logic               reti_stb,
    output logic               irq_pending,
    output logic [VEC_W-1:0]   vec_addr
);
    import irq_ctl_pkg::*;

    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int VEC_TOP = NUM_SRC * VEC_STRIDE;

    reg_addr_e          sel;
    logic               wr_req, wr_mask, wr_prio;
    logic [NUM_SRC-1:0] req_q, src_en, pend, clr;
    logic               gie, grant, any_pend;
    logic [PRIO_W-1:0]  prio_q;
    logic [IDX_W-1:0]   win_idx;

    assign sel     = reg_addr_e'(reg_addr);
    assign wr_req  = reg_wr && (sel == ADDR_REQ);
    assign wr_mask = reg_wr && (sel == ADDR_MASK);
    assign wr_prio = reg_wr && (sel == ADDR_PRIO);

    assign pend  = req_q & src_en & {NUM_SRC{gie}};
    assign grant = ack && any_pend;

    // One clear line per source, raised for the granted winner only.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        assign clr[i] = grant && (win_idx == IDX_W'(i));
    end

    irq_req_bank #(.NUM_SRC(NUM_SRC)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_set (ei_stb),
        .evt     (src_evt),
        .wr_en   (wr_req),
        .wr_data (reg_wdata[NUM_SRC-1:0]),
        .clr     (clr),
        .req_q   (req_q)
    );

    irq_ctl_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (wr_mask),
        .mask_wdata (reg_wdata[NUM_SRC-1:0]),
        .gie_wdata  (reg_wdata[GIE_BIT]),
        .prio_wr    (wr_prio),
        .prio_wdata (reg_wdata[PRIO_W-1:0]),
        .ei_stb     (ei_stb),
        .di_stb     (di_stb),
        .grant      (grant),
        .reti_stb   (reti_stb),
        .src_en     (src_en),
        .gie        (gie),
        .prio_q     (prio_q)
    );

    irq_prio_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .prio_sel (prio_q),
        .any_pend (any_pend),
        .win_idx  (win_idx)
    );

    assign irq_pending = any_pend;
    assign vec_addr    = VEC_W'(win_idx) * VEC_W'(VEC_STRIDE);

    // Register read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            ADDR_REQ:  reg_rdata = DATA_W'(req_q);
            ADDR_MASK: begin
                reg_rdata          = DATA_W'(src_en);
                reg_rdata[GIE_BIT] = gie;
            end
            ADDR_PRIO: reg_rdata = DATA_W'(prio_q);
            default:   reg_rdata = '0;
        endcase
    end

    AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (vec_addr < VEC_W'(VEC_TOP))); // R6

    AST_PEND_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> gie); // R4

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src_evt = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ei_stb = 1'b0, di_stb = 1'b0, ack = 1'b0, reti_stb = 1'b0;
    logic        irq_pending;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ei_stb(ei_stb), .di_stb(di_stb), .ack(ack), .reti_stb(reti_stb),
        .irq_pending(irq_pending), .vec_addr(vec_addr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_evt(input logic [5:0] e);
        @(negedge clk);
        src_evt = e;
        @(negedge clk);
        src_evt = '0;
    endtask

    // Expected winner from the ranking rule of R5.
    function automatic int exp_win(input logic [5:0] p, input int code);
        int base;
        base = (code < NSRC) ? code : 0;
        for (int k = 0; k < NSRC; k++) begin
            if (p[(base + k) % NSRC]) return (base + k) % NSRC;
        end
        return 0;
    endfunction

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check("R1 req", d, 8'h00);
        rd(2'd1, d); check("R1 mask", d, 8'h00);
        rd(2'd2, d); check("R1 prio", d, 8'h00);
        check("R1 pending", irq_pending, 0);

        // R2 locked before first enable command
        wr(2'd1, 8'hBF);
        pulse_evt(6'h3F);
        wr(2'd0, 8'h3F);
        rd(2'd0, d); check("R2 req locked", d, 8'h00);
        check("R2 pending", irq_pending, 0);

        // Release with enable command
        @(negedge clk); ei_stb = 1'b1; @(negedge clk); ei_stb = 1'b0;
        rd(2'd1, d); check("R10 mask after ei", d, 8'hBF);

        // R3 latching
        pulse_evt(6'b000101);
        repeat (3) @(negedge clk);
        rd(2'd0, d); check("R3 latched", d, 8'h05);
        check("R4 pending", irq_pending, 1);
        check("R6 vec src0", vec_addr, 16'd0);
        wr(2'd0, 8'h12);
        rd(2'd0, d); check("R3 write", d, 8'h12);

        // R11 map
        wr(2'd1, 8'hFF);
        rd(2'd1, d); check("R11 bit6 zero", d, 8'hBF);
        rd(2'd3, d); check("R11 addr3", d, 8'h00);
        wr(2'd2, 8'hFD);
        rd(2'd2, d); check("R11 prio field", d, 8'h05);

        // R5/R6 sweep: every priority code and request pattern
        for (int code = 0; code < 8; code++) begin
            wr(2'd2, 8'(code));
            for (int r = 1; r < 64; r++) begin
                wr(2'd0, 8'(r));
                check("R4 pending sweep", irq_pending, 1);
                check("R5 R6 vec sweep", vec_addr, 16'(2 * exp_win(6'(r), code)));
            end
        end

        // R4 enable sweep with all requests set
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h3F);
        for (int m = 0; m < 64; m++) begin
            wr(2'd1, 8'h80 | 8'(m));
            check("R4 mask gate", irq_pending, (m != 0));
            if (m != 0) check("R5 mask vec", vec_addr, 16'(2 * exp_win(6'(m), 0)));
        end

        // R10 disable and register-written enable
        @(negedge clk); di_stb = 1'b1; @(negedge clk); di_stb = 1'b0;
        rd(2'd1, d); check("R10 di clears", d, 8'h3F);
        check("R4 gie off", irq_pending, 0);
        wr(2'd1, 8'hBF);
        check("R10 write enables", irq_pending, 1);
        wr(2'd1, 8'h3F);
        check("R10 write disables", irq_pending, 0);
        wr(2'd1, 8'hBF);

        // R7 grant
        wr(2'd0, 8'b0001_0100);
        check("R6 vec src2", vec_addr, 16'd4);
        @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
        rd(2'd0, d); check("R7 clears winner", d, 8'h10);
        rd(2'd1, d); check("R7 gie cleared", d, 8'h3F);
        check("R7 pending off", irq_pending, 0);

        // R9 return
        @(negedge clk); reti_stb = 1'b1; @(negedge clk); reti_stb = 1'b0;
        rd(2'd1, d); check("R9 gie restored", d, 8'hBF);
        check("R9 vec src4", vec_addr, 16'd8);

        // R8 collision of event and acknowledge
        @(negedge clk); ack = 1'b1; src_evt = 6'b01_0000;
        @(negedge clk); ack = 1'b0; src_evt = '0;
        rd(2'd0, d); check("R8 bit kept", d, 8'h10);
        rd(2'd1, d); check("R8 gie cleared", d, 8'h3F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule